// File: doc/BRIEF.md
# ADC Conversion Frame Controller

This block runs the serial side of a 12-bit, eight-input successive-approximation converter that is wired for single-ended unipolar inputs with its common pin at ground. Each accepted start produces one fixed-length frame counted in cycles of the controller clock, which also sets the serial bit rate. The frame has four parts. A convert pulse starts the conversion. A wait covers the worst-case conversion time. A burst of exactly twelve serial clocks follows. An idle tail pads the frame out to the sample period.

During the burst, the block shifts a six-bit configuration word out on the data-out line, most significant bit first. It shifts twelve result bits in from the data-in line, also most significant bit first. The result register and the done flag change only once all twelve bits have been received, so the result output never holds a partial word.

The converter returns the conversion that was started in the current frame. That conversion uses the channel written during the previous frame. For this reason, the first result after a change on `chan_sel` belongs to the old channel and should be discarded by the user.

Top module: `adc_frame_ctrl`

## Requirements
- R1: A frame starts when `start` is sampled high on a rising clock edge while it was low on the edge before, provided no frame is running. Keeping `start` high does not start a second frame. A rising edge of `start` during a running frame is ignored.
- R2: `adc_convst` is high for exactly PULSE_TICKS cycles (default 4), beginning in the first cycle after the edge that accepts the start.
- R3: Each frame produces exactly NBITS (12) pulses on `adc_sck`, and each pulse is high for the first half of a clock cycle. The first pulse starts CONV_TICKS+1 cycles after the accepting edge. `adc_sck` is low at all other times.
- R4: A frame lasts CONV_TICKS+NBITS+TAIL_TICKS cycles. A new start is accepted once that time has passed.
- R5: The configuration word is {1, chan[0], chan[2], chan[1], 1, 0}, listed from bit 5 down to bit 0. Bit 5 selects single-ended mode, bit 4 holds the odd-input bit, bits 3 and 2 are the pair select, bit 1 selects unipolar, and bit 0 (sleep) is 0. The word is sent MSB first, and the converter samples it on the rising edges of the first six `adc_sck` pulses. `chan_sel` is latched when the frame is accepted, so changes to it later in the frame have no effect on that frame.
- R6: From the start of the frame up to the first `adc_sck` pulse, `adc_sdi` holds bit 5 of the word. After the sixth bit has been sampled, and whenever no frame is running, `adc_sdi` is 0.
- R7: `adc_sdo` is sampled on the falling clock edge that ends each `adc_sck` pulse. The first sample is bit 11 of `result`.
- R8: `result` and `done` are both updated on the rising edge that comes CONV_TICKS+NBITS+1 edges after the accepting edge.
- R9: `done` goes low on the edge that accepts a frame and stays low until that frame's result is loaded. `result` keeps its previous value until then.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and serial bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | A rising edge requests one frame |
| chan_sel | input | 3 | Input channel to select, latched at frame start |
| adc_sdo | input | 1 | Serial result bits from the converter |
| adc_convst | output | 1 | Convert-start pulse to the converter |
| adc_sck | output | 1 | Gated serial clock |
| adc_sdi | output | 1 | Serial configuration word to the converter |
| result | output | 12 | Last complete conversion result |
| done | output | 1 | High from result load until the next accepted start |

## Verification
The bench keeps the 64-cycle conversion wait, the 4-cycle pulse and the 12-bit burst, and cuts the idle tail to 20 cycles. The shorter tail lets nine frames run within a short simulation. The converter model in the bench decodes each received word and answers the next frame from the channel it selected. This exposes the one-frame channel lag, a channel change in the middle of a frame, extra start edges during a frame, and a start held high across the end of a frame, while the exact pulse counts and the done timing are checked against the production wait length.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int CFG_BITS = 6;
  localparam int CH_W     = 3;

  typedef enum logic [1:0] {
    SDI_OFF,
    SDI_INIT,
    SDI_SHIFT,
    SDI_DONE
  } sdi_phase_e;

  // single-ended, odd bit, pair select, unipolar, no sleep
  function automatic logic [CFG_BITS-1:0] cfg_word(input logic [CH_W-1:0] ch);
    return {1'b1, ch[0], ch[2], ch[1], 1'b1, 1'b0};
  endfunction
endpackage

// File: rtl/adc_frame_timer.sv
module adc_frame_timer #(
  parameter int CONV_TICKS  = 64,
  parameter int NBITS       = 12,
  parameter int TAIL_TICKS  = 320,
  parameter int PULSE_TICKS = 4,
  parameter int CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             go,
  output logic             busy,
  output logic [CNT_W-1:0] tick,
  output logic             convst,
  output logic             sck_gate
);
  localparam int FRAME_LEN = CONV_TICKS + NBITS + TAIL_TICKS;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] XFER_LO   = CNT_W'(CONV_TICKS);
  localparam logic [CNT_W-1:0] XFER_HI   = CNT_W'(CONV_TICKS + NBITS - 1);
  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_TICKS);

  logic start_q;

  assign go     = start & ~start_q & ~busy;
  assign convst = busy & (tick < PULSE_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy    <= 1'b0;
      tick    <= '0;
    end else begin
      start_q <= start;
      if (go) begin
        busy <= 1'b1;
        tick <= '0;
      end else if (busy) begin
        if (tick == LAST_TICK) begin
          busy <= 1'b0;
          tick <= '0;
        end else begin
          tick <= tick + CNT_W'(1);
        end
      end
    end
  end

  // gate changes while clk is low so each pulse is a clean high half
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sck_gate <= 1'b0;
    else        sck_gate <= busy & (tick >= XFER_LO) & (tick <= XFER_HI);
  end

  p_tick_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick != LAST_TICK) |=> (busy && tick == $past(tick) + CNT_W'(1)));
  p_frame_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick == LAST_TICK) |=> !busy);
  p_sck_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !sck_gate);
  p_no_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !start_q && tick != LAST_TICK) |=> tick != '0);
endmodule

// File: rtl/adc_cfg_tx.sv
module adc_cfg_tx
  import adc_frame_pkg::*;
#(
  parameter int CONV_TICKS = 64,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             busy,
  input  logic [CNT_W-1:0] tick,
  input  logic [CH_W-1:0]  chan,
  output logic             sdi
);
  localparam logic [CNT_W-1:0] XFER_LO  = CNT_W'(CONV_TICKS);
  localparam logic [CNT_W-1:0] SHIFT_HI = CNT_W'(CONV_TICKS + CFG_BITS - 1);

  logic [CFG_BITS-1:0] word_q;
  logic [CFG_BITS-1:0] shifted;
  logic [CNT_W-1:0]    offs;
  sdi_phase_e          phase;
  logic                sdi_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (go) word_q <= cfg_word(chan);
  end

  assign offs    = tick - XFER_LO;
  assign shifted = word_q << offs;

  always_comb begin
    if (!busy)                 phase = SDI_OFF;
    else if (tick <= XFER_LO)  phase = SDI_INIT;
    else if (tick <= SHIFT_HI) phase = SDI_SHIFT;
    else                       phase = SDI_DONE;
  end

  always_comb begin
    unique case (phase)
      SDI_INIT:  sdi_d = word_q[CFG_BITS-1];
      SDI_SHIFT: sdi_d = shifted[CFG_BITS-1];
      default:   sdi_d = 1'b0;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdi <= 1'b0;
    else        sdi <= sdi_d;
  end

  p_sdi_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !sdi);
  p_sdi_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick <= XFER_LO) |-> sdi == word_q[CFG_BITS-1]);
  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go) |=> $stable(word_q));
endmodule

// File: rtl/adc_result_rx.sv
module adc_result_rx #(
  parameter int CONV_TICKS = 64,
  parameter int NBITS      = 12,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             busy,
  input  logic [CNT_W-1:0] tick,
  input  logic             sdo,
  output logic [NBITS-1:0] result,
  output logic             done
);
  localparam int CAP_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] CAP_LO   = CNT_W'(CONV_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CONV_TICKS + NBITS);

  logic [NBITS-1:0] shreg;
  logic [CAP_W-1:0] cap_cnt;
  logic             load;

  // sample on the falling edge that ends each serial pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cap_cnt <= '0;
    end else if (busy && tick >= CAP_LO && tick <= LAST_BIT) begin
      shreg   <= {shreg[NBITS-2:0], sdo};
      cap_cnt <= cap_cnt + CAP_W'(1);
    end else if (busy && tick < CAP_LO) begin
      cap_cnt <= '0;
    end
  end

  assign load = busy & (tick == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else if (go) begin
      done <= 1'b0;
    end else if (load) begin
      result <= shreg;
      done   <= 1'b1;
    end
  end

  p_full_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> cap_cnt == CAP_W'(NBITS));
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !done);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(result));
  p_done_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> done);
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int CONV_TICKS  = 64,
  parameter int NBITS       = 12,
  parameter int TAIL_TICKS  = 320,
  parameter int PULSE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             adc_sdo,
  output logic             adc_convst,
  output logic             adc_sck,
  output logic             adc_sdi,
  output logic [NBITS-1:0] result,
  output logic             done
);
  localparam int FRAME_LEN = CONV_TICKS + NBITS + TAIL_TICKS;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic             go;
  logic             busy;
  logic [CNT_W-1:0] tick;
  logic             sck_gate;

  adc_frame_timer #(
    .CONV_TICKS(CONV_TICKS), .NBITS(NBITS), .TAIL_TICKS(TAIL_TICKS),
    .PULSE_TICKS(PULSE_TICKS), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .go(go), .busy(busy),
    .tick(tick), .convst(adc_convst), .sck_gate(sck_gate)
  );

  adc_cfg_tx #(.CONV_TICKS(CONV_TICKS), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .tick(tick),
    .chan(chan_sel), .sdi(adc_sdi)
  );

  adc_result_rx #(.CONV_TICKS(CONV_TICKS), .NBITS(NBITS), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .tick(tick),
    .sdo(adc_sdo), .result(result), .done(done)
  );

  assign adc_sck = clk & sck_gate;

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!adc_convst && !done && result == '0));
endmodule

// File: tb/adc_frame_ctrl_test.sv
`timescale 1ns/100ps
module adc_frame_ctrl_test;
  localparam int CONV  = 64;
  localparam int NB    = 12;
  localparam int TAIL  = 20;
  localparam int PULSE = 4;
  localparam int FRAME = CONV + NB + TAIL;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, adc_sdo = 1'b0;
  logic [2:0]  chan_sel = 3'd0;
  logic        adc_convst, adc_sck, adc_sdi, done;
  logic [11:0] result;

  adc_frame_ctrl #(.CONV_TICKS(CONV), .NBITS(NB), .TAIL_TICKS(TAIL),
                   .PULSE_TICKS(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .adc_sdo(adc_sdo), .adc_convst(adc_convst), .adc_sck(adc_sck),
    .adc_sdi(adc_sdi), .result(result), .done(done));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model: answers with the channel selected in the previous frame
  logic [11:0] adc_sh = '0;
  logic [5:0]  rx_cfg = '0;
  logic [2:0]  adc_ch = '0;
  int sck_cnt = 0, sdi_tail_ones = 0, conv_frames = 0;

  always @(posedge adc_convst) begin
    adc_sh = {adc_ch, 9'((conv_frames * 37 + 11) % 512)};
    conv_frames++;
    adc_sdo = adc_sh[11];
    sck_cnt = 0;
    sdi_tail_ones = 0;
  end
  always @(posedge adc_sck) begin
    if (sck_cnt < 6) rx_cfg = {rx_cfg[4:0], adc_sdi};
    else if (adc_sdi) sdi_tail_ones++;
    sck_cnt++;
    if (sck_cnt == 6) adc_ch = {rx_cfg[3], rx_cfg[2], rx_cfg[4]};
  end
  always @(negedge adc_sck) begin
    #1;
    adc_sh = adc_sh << 1;
    adc_sdo = adc_sh[11];
  end

  // scoreboard
  typedef struct packed { logic [11:0] res; logic [5:0] word; } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;
  int t0 = 0, conv_hi = 0, frames_sent = 0;
  logic [11:0] last_res = '0;
  logic [2:0]  prev_ch = '0;
  bit done_q = 0, in_frame = 0;

  always @(posedge clk) begin
    #1;
    if (in_frame) begin
      if (adc_convst) conv_hi++;
      if (cyc == t0) check("R9", "done low after accept", int'(done), 0);
      if (cyc - t0 == CONV / 2) begin
        check("R6", "sdi holds word MSB in wait", int'(adc_sdi), 1);
        check("R9", "result held mid-frame", int'(result), int'(last_res));
      end
    end
    if (done && !done_q) begin
      if (exp_q.size() == 0) begin
        check("R1", "unexpected extra frame", 1, 0);
      end else begin
        mon_e = exp_q.pop_front();
        check("R7", "result word (prior channel)", int'(result), int'(mon_e.res));
        check("R5", "config word seen by converter", int'(rx_cfg), int'(mon_e.word));
        check("R8", "done edge offset", cyc - t0, CONV + NB + 1);
        check("R3", "sck pulses per frame", sck_cnt, NB);
        check("R6", "sdi ones after word", sdi_tail_ones, 0);
        check("R2", "convst high cycles", conv_hi, PULSE);
        last_res = result;
      end
      in_frame = 0;
    end
    done_q = done;
  end

  task automatic run_frame(input logic [2:0] ch, input bit poke);
    exp_t e;
    e.res  = {prev_ch, 9'((frames_sent * 37 + 11) % 512)};
    e.word = {1'b1, ch[0], ch[2], ch[1], 1'b1, 1'b0};
    exp_q.push_back(e);
    prev_ch = ch;
    frames_sent++;
    @(negedge clk);
    chan_sel = ch; start = 1'b1; conv_hi = 0;
    t0 = cyc + 1; in_frame = 1;
    repeat (10) @(negedge clk);
    chan_sel = ~ch;                      // R5: ignored after latch
    if (poke) begin                      // R1: edge during a running frame
      start = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    repeat (FRAME + 4) @(negedge clk);   // start may stay high: R1
    start = 1'b0;
    @(posedge clk); #1;
    check("R4", "queue drained after frame", exp_q.size(), 0);
    check("R1", "done still set, no retrigger", int'(done), 1);
    check("R3", "no sck pulses after burst", sck_cnt, NB);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "convst in reset", int'(adc_convst), 0);
    check("R10", "sck in reset", int'(adc_sck), 0);
    check("R10", "sdi in reset", int'(adc_sdi), 0);
    check("R10", "done in reset", int'(done), 0);
    check("R10", "result in reset", int'(result), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(3'd3, 1'b0);
    run_frame(3'd3, 1'b1);
    run_frame(3'd5, 1'b0);
    run_frame(3'd0, 1'b1);
    run_frame(3'd7, 1'b0);
    run_frame(3'd2, 1'b0);
    run_frame(3'd6, 1'b1);
    run_frame(3'd1, 1'b0);
    run_frame(3'd4, 1'b0);
    check("R4", "frames converted", conv_frames, 9);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule